// File: doc/BRIEF.md
# Tone Presence Qualifier

This block converts a stream of per-sample level measurements into a steady "tone present" indication for two signal directions, receive and transmit. On every sample strobe each direction presents an in-band level and an out-of-band level. A sample qualifies when the in-band level is above a programmed floor and the in-band level exceeds the out-of-band level by more than a programmed margin.

The indication turns on only after qualifying samples have persisted for a programmed number of strobes. Short gaps in that run are forgiven, so a brief dropout does not restart the count. The indication turns off under the mirror-image rule: the failure must persist for its own programmed time, and short recoveries count as continued failure. Every change of an indication raises a one-cycle event and sets a sticky status bit. Software clears that bit by writing a 1 to it. All thresholds and times are programmed through a small write-only configuration port.

Top module: `tpq_top`

## Requirements
- R1: A strobe qualifies for a direction when in-band > floor (addr 0) AND the signed difference in-band minus out-of-band > margin (addr 1). Both comparisons are unsigned-level and strict, so an out-of-band level above the in-band level never qualifies.
- R2: While the flag is 0, rise timing starts at the first qualifying strobe. A run counter advances on every later strobe, gaps included. The flag goes to 1 on a qualifying strobe at which the run counter is at least the rise time (addr 2).
- R3: During rise timing, a gap of up to the rise gap limit (addr 3) non-qualifying strobes is forgiven and the run counter keeps advancing. The strobe that makes a gap one longer than the limit resets the timing to idle.
- R4: While the flag is 1, fall timing starts at the first non-qualifying strobe. The flag goes to 0 on a non-qualifying strobe at which the run counter is at least the fall time (addr 4).
- R5: During fall timing, a run of qualifying strobes resets the timing once its length reaches the fall gap limit (addr 5), where a limit of 0 acts as 1. Shorter runs count as continued failure.
- R6: With a rise or fall time of 0, the flag changes on the first strobe that meets the respective rule.
- R7: The two directions are independent. Bit 0 of every 2-bit output belongs to receive and bit 1 to transmit.
- R8: det_event[i] is high for exactly the one cycle after the clock edge at which det_flags[i] changes, and is low otherwise.
- R9: det_sticky[i] sets with the event. A write to addr 6 clears each bit whose data bit is 1, and a set in the same cycle wins over the clear.
- R10: Configuration registers at addr 0 to 5 take a write in one cycle and apply from the next strobe onward. The low LVL_W bits of the data are used for the floor and margin, and the low T_W bits for the times.
- R11: After reset the flags, events and sticky bits are 0, all registers are 0 and no timing is in progress.
- R12: Without a strobe, the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| rx_inband | input | LVL_W | Receive in-band level |
| rx_outband | input | LVL_W | Receive out-of-band level |
| tx_inband | input | LVL_W | Transmit in-band level |
| tx_outband | input | LVL_W | Transmit out-of-band level |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| det_flags | output | 2 | Tone present flags (bit 0 receive, bit 1 transmit) |
| det_event | output | 2 | One-cycle change pulses |
| det_sticky | output | 2 | Sticky change status |

## Verification
The embedded properties assume that reset is released synchronously to the clock. They also assume that a strobe the design sees is a clean one-cycle level, with each level input stable in the cycle it is sampled. The bench drives all inputs on the falling edge and separates strobes by at least one idle cycle. It keeps the programmed times far below the counter range, so saturation never masks a timing boundary. Random level pairs are drawn from a sticky two-state pattern that produces long runs with scattered gaps of controlled length. The times are re-programmed between phases, so both the forgive and the restart sides of each gap limit are reached.

// File: rtl/tpq_pkg.sv
package tpq_pkg;

  localparam int NCH   = 2;
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;

  typedef enum logic [2:0] {
    A_FLOOR  = 3'd0,
    A_MARGIN = 3'd1,
    A_RTIME  = 3'd2,
    A_RGAP   = 3'd3,
    A_FTIME  = 3'd4,
    A_FGAP   = 3'd5,
    A_STCLR  = 3'd6
  } cfg_addr_e;

  // Qualification test on zero-extended 32-bit operands.
  function automatic logic tone_cond(input logic [31:0] inb, input logic [31:0] oob,
                                     input logic [31:0] flr, input logic [31:0] mrg);
    logic signed [33:0] diff;
    diff = $signed({2'b00, inb}) - $signed({2'b00, oob});
    return (inb > flr) && (diff > $signed({2'b00, mrg}));
  endfunction

  // Fall gap: restart when run length >= limit (0 acts as 1), expressed
  // as an exclusive "gap > value" limit for the shared engine.
  function automatic logic [31:0] fall_gap_excl(input logic [31:0] lim);
    return (lim == 32'd0) ? 32'd0 : lim - 32'd1;
  endfunction

endpackage

// File: rtl/tpq_cfg.sv
module tpq_cfg
  import tpq_pkg::*;
#(
  parameter int LVL_W = 12,
  parameter int T_W   = 8,
  parameter int DW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [LVL_W-1:0]  floor_q,
  output logic [LVL_W-1:0]  margin_q,
  output logic [T_W-1:0]    rtime_q,
  output logic [T_W-1:0]    rgap_q,
  output logic [T_W-1:0]    ftime_q,
  output logic [T_W-1:0]    fgap_q,
  output logic [NCH-1:0]    st_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q  <= '0;
      margin_q <= '0;
      rtime_q  <= '0;
      rgap_q   <= '0;
      ftime_q  <= '0;
      fgap_q   <= '0;
    end else if (we) begin
      case (cfg_addr_e'(addr))
        A_FLOOR:  floor_q  <= wdata[LVL_W-1:0];
        A_MARGIN: margin_q <= wdata[LVL_W-1:0];
        A_RTIME:  rtime_q  <= wdata[T_W-1:0];
        A_RGAP:   rgap_q   <= wdata[T_W-1:0];
        A_FTIME:  ftime_q  <= wdata[T_W-1:0];
        A_FGAP:   fgap_q   <= wdata[T_W-1:0];
        default: ;
      endcase
    end
  end

  assign st_clr = (we && addr == A_STCLR) ? wdata[NCH-1:0] : '0;

endmodule

// File: rtl/tpq_qual.sv
module tpq_qual #(
  parameter int T_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb,
  input  logic           cond,
  input  logic [T_W-1:0] qual_time,
  input  logic [T_W-1:0] gap_lim,
  output logic           flag,
  output logic           toggle
);

  logic           flag_q;
  logic [T_W-1:0] run_cnt;
  logic [T_W-1:0] gap_cnt;
  logic [T_W:0]   gap_nxt;
  logic [T_W-1:0] run_inc;
  logic           meet;
  logic           gap_over;
  logic           restart;
  logic           timing;

  assign meet     = cond ^ flag_q;
  assign timing   = (run_cnt != '0);
  assign gap_nxt  = {1'b0, gap_cnt} + 1'b1;
  assign gap_over = gap_nxt > {1'b0, gap_lim};
  assign run_inc  = (run_cnt == '1) ? run_cnt : run_cnt + 1'b1;
  assign toggle   = stb && meet && (run_cnt >= qual_time);
  assign restart  = stb && !meet && timing && gap_over;
  assign flag     = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      run_cnt <= '0;
      gap_cnt <= '0;
    end else if (stb) begin
      if (toggle) begin
        flag_q  <= ~flag_q;
        run_cnt <= '0;
        gap_cnt <= '0;
      end else if (meet) begin
        run_cnt <= run_inc;
        gap_cnt <= '0;
      end else if (timing) begin
        if (gap_over) begin
          run_cnt <= '0;
          gap_cnt <= '0;
        end else begin
          run_cnt <= run_inc;
          gap_cnt <= gap_nxt[T_W-1:0];
        end
      end
    end
  end

  assert_hold_no_stb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(flag_q));

  assert_no_flip_in_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !meet) |=> $stable(flag_q));

  assert_restart_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (run_cnt == '0 && gap_cnt == '0));

  assert_zero_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && meet && qual_time == '0) |=> (flag_q != $past(flag_q)));

endmodule

// File: rtl/tpq_top.sv
module tpq_top
  import tpq_pkg::*;
#(
  parameter  int LVL_W = 12,
  parameter  int T_W   = 8,
  localparam int DW    = (LVL_W > T_W) ? LVL_W : T_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [LVL_W-1:0] rx_inband,
  input  logic [LVL_W-1:0] rx_outband,
  input  logic [LVL_W-1:0] tx_inband,
  input  logic [LVL_W-1:0] tx_outband,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [1:0]       det_flags,
  output logic [1:0]       det_event,
  output logic [1:0]       det_sticky
);

  logic [LVL_W-1:0] floor_q, margin_q;
  logic [T_W-1:0]   rtime_q, rgap_q, ftime_q, fgap_q;
  logic [NCH-1:0]   st_clr;
  logic [NCH-1:0]   tog;
  logic [NCH-1:0]   flg;
  logic [LVL_W-1:0] inb [NCH];
  logic [LVL_W-1:0] oob [NCH];
  logic [T_W-1:0]   fgap_excl;

  assign inb[CH_RX] = rx_inband;
  assign oob[CH_RX] = rx_outband;
  assign inb[CH_TX] = tx_inband;
  assign oob[CH_TX] = tx_outband;
  assign fgap_excl  = T_W'(fall_gap_excl(32'(fgap_q)));

  tpq_cfg #(.LVL_W(LVL_W), .T_W(T_W), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .floor_q(floor_q), .margin_q(margin_q), .rtime_q(rtime_q), .rgap_q(rgap_q),
    .ftime_q(ftime_q), .fgap_q(fgap_q), .st_clr(st_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic           cnd;
    logic [T_W-1:0] tq;
    logic [T_W-1:0] gl;

    assign cnd = tone_cond(32'(inb[i]), 32'(oob[i]), 32'(floor_q), 32'(margin_q));
    assign tq  = flg[i] ? ftime_q : rtime_q;
    assign gl  = flg[i] ? fgap_excl : rgap_q;

    tpq_qual #(.T_W(T_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .cond(cnd),
      .qual_time(tq), .gap_lim(gl), .flag(flg[i]), .toggle(tog[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        det_event[i]  <= 1'b0;
        det_sticky[i] <= 1'b0;
      end else begin
        det_event[i]  <= tog[i];
        det_sticky[i] <= (det_sticky[i] & ~st_clr[i]) | tog[i];
      end
    end

    assert_evt_tracks_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      det_event[i] == (det_flags[i] != $past(det_flags[i])));

    assert_sticky_with_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      det_event[i] |-> det_sticky[i]);
  end

  assign det_flags = flg;

endmodule

// File: tb/sim_tpq_top.sv
module sim_tpq_top;

  localparam int LVL_W = 12;
  localparam int T_W   = 8;
  localparam int DW    = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_stb = 1'b0;
  logic [LVL_W-1:0] rx_inband = '0, rx_outband = '0, tx_inband = '0, tx_outband = '0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [DW-1:0]    cfg_wdata = '0;
  logic [1:0]       det_flags, det_event, det_sticky;

  int n_tests = 0;
  int n_fail  = 0;

  // bench copy of programmed configuration
  int c_flr = 0, c_mrg = 0, c_rt = 0, c_rg = 0, c_ft = 0, c_fg = 0;
  // bench model state per direction
  bit m_flag [2];
  bit m_evt  [2];
  bit m_st   [2];
  int m_run  [2];
  int m_gap  [2];

  tpq_top #(.LVL_W(LVL_W), .T_W(T_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .rx_inband(rx_inband), .rx_outband(rx_outband),
    .tx_inband(tx_inband), .tx_outband(tx_outband),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .det_flags(det_flags), .det_event(det_event), .det_sticky(det_sticky)
  );

  always #5 clk = ~clk;

  function automatic bit qualifies(int inb, int oob);
    return (inb > c_flr) && ((inb - oob) > c_mrg);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(int ch, bit c);
    bit hit  = m_flag[ch] ? !c : c;
    int need = m_flag[ch] ? c_ft : c_rt;
    bit drop;
    m_evt[ch] = 1'b0;
    if (hit) begin
      if (m_run[ch] >= need) begin
        m_flag[ch] = !m_flag[ch];
        m_evt[ch]  = 1'b1;
        m_run[ch]  = 0;
      end else begin
        m_run[ch]++;
      end
      m_gap[ch] = 0;
    end else if (m_run[ch] > 0) begin
      m_gap[ch]++;
      drop = m_flag[ch] ? (m_gap[ch] >= ((c_fg > 0) ? c_fg : 1)) : (m_gap[ch] > c_rg);
      if (drop) begin
        m_run[ch] = 0;
        m_gap[ch] = 0;
      end else begin
        m_run[ch]++;
      end
    end
  endtask

  task automatic cfg_write(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = DW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: c_flr = data;
      1: c_mrg = data;
      2: c_rt  = data;
      3: c_rg  = data;
      4: c_ft  = data;
      5: c_fg  = data;
      6: for (int i = 0; i < 2; i++) if (data[i]) m_st[i] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic check_all(string tag);
    chk({tag, " flags"},  int'(det_flags),  int'({m_flag[1], m_flag[0]}));
    chk({tag, " event"},  int'(det_event),  int'({m_evt[1], m_evt[0]}));
    chk({tag, " sticky"}, int'(det_sticky), int'({m_st[1], m_st[0]}));
  endtask

  // one strobe with optional same-cycle sticky clear, then one idle cycle
  task automatic strobe(string tag, int ri, int ro, int ti, int to, int clr = 0);
    bit cr = qualifies(ri, ro);
    bit ct = qualifies(ti, to);
    @(negedge clk);
    rx_inband = LVL_W'(ri); rx_outband = LVL_W'(ro);
    tx_inband = LVL_W'(ti); tx_outband = LVL_W'(to);
    smp_stb = 1'b1;
    if (clr != 0) begin cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = DW'(clr); end
    @(posedge clk);
    for (int i = 0; i < 2; i++) if (clr[i]) m_st[i] = 1'b0;
    model_step(0, cr);
    model_step(1, ct);
    for (int i = 0; i < 2; i++) if (m_evt[i]) m_st[i] = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; cfg_we = 1'b0;
    check_all(tag);
    @(negedge clk);
    m_evt[0] = 1'b0; m_evt[1] = 1'b0;
    check_all({tag, "/R12 idle"});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit mode [2];
    int lv [4];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      m_flag[i] = 0; m_evt[i] = 0; m_st[i] = 0; m_run[i] = 0; m_gap[i] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 after release");
    // R11: registers zero, so in=1 out=0 qualifies with zero times
    strobe("R11 zero config", 1, 0, 0, 0);
    chk("R11 zero floor/margin sets rx", int'(det_flags), 1);
    strobe("R6 zero ftime clears", 0, 0, 0, 0);

    // R1: comparison boundaries
    cfg_write(0, 100); cfg_write(1, 50);
    strobe("R1 margin+1", 101, 50, 101, 51);
    chk("R1 rx set tx not", int'(det_flags), 1);
    strobe("R1 floor equal", 100, 0, 150, 300);
    chk("R1 floor equal clears, negative diff", int'(det_flags), 0);
    strobe("R1/R7 tx only", 0, 0, 200, 10);
    chk("R7 tx bit1 only", int'(det_flags), 2);
    strobe("R6 both fail", 0, 0, 0, 0);

    // R2: rise time 3 -> set on 4th qualifying strobe
    cfg_write(2, 3);
    for (int k = 0; k < 3; k++) strobe("R2 rising", 200, 0, 0, 0);
    chk("R2 not yet", int'(det_flags), 0);
    strobe("R2 fourth", 200, 0, 0, 0);
    chk("R2 set on 4th", int'(det_flags), 1);

    // R4/R5: fall time 4, gap limit 2 (a 1-strobe recovery is forgiven)
    cfg_write(4, 4); cfg_write(5, 2);
    strobe("R4 fail1", 0, 0, 0, 0);
    strobe("R5 short recovery", 200, 0, 0, 0);
    strobe("R4 fail2", 0, 0, 0, 0);
    strobe("R4 fail3", 0, 0, 0, 0);
    chk("R5 still set", int'(det_flags), 1);
    strobe("R4 fail4", 0, 0, 0, 0);
    chk("R4 cleared", int'(det_flags), 0);

    // R3: rise time 5, gap 2: gap of 2 forgiven, gap of 3 restarts
    cfg_write(2, 5); cfg_write(3, 2);
    strobe("R3 a", 200, 0, 0, 0); strobe("R3 b", 200, 0, 0, 0);
    strobe("R3 gap1", 0, 0, 0, 0); strobe("R3 gap2", 0, 0, 0, 0);
    strobe("R3 c", 200, 0, 0, 0);
    strobe("R3 d", 200, 0, 0, 0);
    chk("R3 forgiven gap sets", int'(det_flags), 1);
    cfg_write(4, 0);
    strobe("R6 clear", 0, 0, 0, 0);
    strobe("R3 e", 200, 0, 0, 0);
    for (int k = 0; k < 3; k++) strobe("R3 long gap", 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) strobe("R3 restarted", 200, 0, 0, 0);
    chk("R3 restart holds flag", int'(det_flags), 0);

    // R9: clear, and set wins over same-cycle clear
    cfg_write(6, 3);
    chk("R9 cleared", int'(det_sticky), 0);
    strobe("R9 set wins", 200, 0, 0, 0, 3);
    chk("R9 set beats clear", int'(det_sticky), 1);
    cfg_write(6, 2);
    chk("R9 zero bit ignored", int'(det_sticky), 1);

    // R10 / R7 random phases
    for (int ph = 0; ph < 6; ph++) begin
      cfg_write(0, 300 + int'($urandom_range(0, 400)));
      cfg_write(1, int'($urandom_range(0, 300)));
      cfg_write(2, int'($urandom_range(0, 12)));
      cfg_write(3, int'($urandom_range(0, 4)));
      cfg_write(4, int'($urandom_range(0, 12)));
      cfg_write(5, int'($urandom_range(0, 4)));
      mode[0] = 0; mode[1] = 0;
      for (int s = 0; s < 400; s++) begin
        for (int c = 0; c < 2; c++) begin
          if ($urandom_range(0, 5) == 0) mode[c] = !mode[c];
          if ($urandom_range(0, 7) == 0) begin
            lv[2*c] = int'($urandom_range(0, 4095));
            lv[2*c+1] = int'($urandom_range(0, 4095));
          end else if (mode[c]) begin
            lv[2*c+1] = int'($urandom_range(0, 500));
            lv[2*c] = lv[2*c+1] + c_mrg + 1 + int'($urandom_range(0, 800));
            if (lv[2*c] <= c_flr) lv[2*c] = c_flr + 1 + int'($urandom_range(0, 100));
            if (lv[2*c] > 4095) lv[2*c] = 4095;
          end else begin
            lv[2*c] = int'($urandom_range(0, 4095));
            lv[2*c+1] = lv[2*c] + int'($urandom_range(0, 300));
            if (lv[2*c+1] > 4095) lv[2*c+1] = 4095;
          end
        end
        if ($urandom_range(0, 60) == 0) cfg_write(6, int'($urandom_range(0, 3)));
        strobe("R7/R10 random", lv[0], lv[1], lv[2], lv[3]);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule